// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block turns single-bit requests from a byte-level sequencer into correctly timed open-drain SCL and SDA activity. It runs from a fast internal clock. Four programmable counts shape every bit: the full SCL period, the part of the period SCL spends low, the setup time for a repeated start or stop, and the time SDA is stable before SCL rises. A typical setting for a 50 MHz clock and a 400 kHz bus is a period of 125, a low time and setup of 62, and a data setup of 7. The bus is never run faster than 400 kHz.

The sequencer offers one of four operations: start, write bit, read bit or stop. It offers an operation only while `reqReady` is high. The block acknowledges each finished operation with a one-cycle `donePulse`. A read also returns the sampled bit on `rxBit`. If SCL is still held low by an earlier bit when a start is requested, the block produces a repeated start. The count for the high phase does not begin until SCL reads back high, so a slave may stretch the clock.

A bus-control pair sits beside the timing path. `runEn` enables normal operation, and `sclRelease` frees a stuck-low SCL. Clearing `runEn` parks the generator so that the counts can be changed safely.

Top module: `i2c_bit_timer`

## Requirements
- R1: While reset is asserted and in the first cycles after it is released, `sclPullLow`, `sdaPullLow` and `donePulse` are 0 and `reqReady` is 1.
- R2: The line outputs are open-drain enables: 1 pulls the line low and 0 releases it. After a stop completes, both enables are 0 and stay 0 while no request arrives.
- R3: A start (`reqOp`=0) issued while SCL is released first keeps both lines released for `cfgSetup` cycles. It then pulls SDA low with SCL released for `cfgSetup` cycles, then pulls SCL low in the same cycle that `donePulse` is high.
- R4: A start issued while SCL is pulled low becomes a repeated start. SCL stays low for `cfgLow` cycles after acceptance, and SDA is released from `cfgDataSetup` cycles before the end of that low time. SCL is then released for `cfgSetup` high cycles with SDA released, and for `cfgSetup` cycles with SDA pulled. SCL is then pulled low with `donePulse`.
- R5: A write bit (`reqOp`=1, `reqBit` carries the value) keeps SCL pulled for `cfgLow` cycles after acceptance. SDA takes the bit (pulled when the bit is 0) exactly `cfgDataSetup` cycles before SCL is released, unless SDA already had that value. SCL is then released for `cfgPeriod`−`cfgLow` high cycles, then pulled again with `donePulse`, and SDA keeps the bit.
- R6: A read bit (`reqOp`=2) keeps the write-bit SCL timing with SDA released. `rxBit` holds the SDA value seen in high cycle number floor((`cfgPeriod`−`cfgLow`)/2), counting from 0.
- R7: A stop (`reqOp`=3) pulls SDA during the last `cfgDataSetup` cycles of the `cfgLow`-cycle low time. It then releases SCL and, after `cfgSetup` high cycles, releases SDA with `donePulse`.
- R8: Each cycle after SCL is released in which `sclIn` still reads low adds one cycle to the released time. The high-phase count, and with it the read sample point, starts only once SCL reads high.
- R9: While `runEn` is 0, the generator is idle from the next cycle on. It drops any operation in progress, ignores requests, produces no `donePulse`, releases SDA and pulls SCL low exactly when `sclRelease` is 0.
- R10: A request that arrives in the same cycle as `runEn`=0 is discarded and does not start after `runEn` returns to 1.
- R11: `reqReady` is 0 from acceptance until `donePulse`, which lasts exactly one cycle, and is 1 in the `donePulse` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | Normal-operation enable |
| sclRelease | input | 1 | When idle-forced, 1 releases SCL and 0 holds it low |
| cfgPeriod | input | CNT_W | Full SCL period in clocks |
| cfgLow | input | CNT_W | SCL low time in clocks |
| cfgSetup | input | CNT_W | Repeated start / stop setup in clocks |
| cfgDataSetup | input | CNT_W | SDA-before-SCL-rise setup in clocks |
| reqValid | input | 1 | Operation request, taken when `reqReady` is 1 |
| reqOp | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| reqBit | input | 1 | Value for a write bit |
| reqReady | output | 1 | Generator idle |
| donePulse | output | 1 | One-cycle completion strobe |
| rxBit | output | 1 | Bit sampled by the last read |
| sclIn | input | 1 | SCL line level read back |
| sdaIn | input | 1 | SDA line level read back |
| sclPullLow | output | 1 | SCL open-drain enable (1 = pull low) |
| sdaPullLow | output | 1 | SDA open-drain enable (1 = pull low) |

## Verification
Two functions can land in the same cycle: a new request being accepted and the normal-operation enable being withdrawn. The bench raises `reqValid` and lowers `runEn` on the same clock edge while the generator is idle, then restores `runEn` and watches several cycles for any sign that the request was kept. It repeats the withdrawal in the middle of a write bit and checks that the lines fall to their forced state one cycle later. The clock-stretch path is judged against arithmetic predictions. The bench holds SCL low for 0 to 2 extra cycles and places the only differing SDA value at the computed midpoint, so a sample taken one cycle early or late returns the wrong bit.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  // Operation codes presented by the byte sequencer
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bitOp_e;

  // Phases of one bit-level operation
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LOWA = 3'd1,   // SCL low, SDA unchanged
    PH_LOWB = 3'd2,   // SCL low, SDA at its new value
    PH_HIGH = 3'd3,   // SCL released, counted once it reads high
    PH_HOLD = 3'd4    // start: SDA low with SCL high
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic sclPull;
    logic sclFree;
    logic sdaLoad;
    logic sdaVal;
    logic sample;
    logic done;
  } lineStrb_t;

endpackage

// File: rtl/i2c_bit_ctrl.sv
module i2c_bit_ctrl
  import i2c_bit_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgDataSetup,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic             reqBit,
  input  logic             sclIn,
  input  logic             sclHeld,
  output logic             reqReady,
  output lineStrb_t        strb
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  phase_e           phase, phaseNx;
  bitOp_e           opR;
  logic             bitR;
  logic [CNT_W-1:0] cnt, cntNx, lim;
  logic             advance, atLast, sdaTarget, spanHigh;

  // Phase length selection
  always_comb begin
    spanHigh = (opR == OP_WRITE) || (opR == OP_READ);
    unique case (phase)
      PH_LOWA: lim = cfgLow - cfgDataSetup;
      PH_LOWB: lim = cfgDataSetup;
      PH_HIGH: lim = spanHigh ? (cfgPeriod - cfgLow) : cfgSetup;
      PH_HOLD: lim = cfgSetup;
      default: lim = CNT_ZERO;
    endcase
  end

  // The high phase waits for SCL to read back high before counting
  assign advance = (phase != PH_HIGH) || sclIn || (cnt != CNT_ZERO);
  assign atLast  = advance && (({1'b0, cnt} + 1'b1) >= {1'b0, lim});

  always_comb begin
    unique case (opR)
      OP_WRITE: sdaTarget = ~bitR;
      OP_STOP:  sdaTarget = 1'b1;
      default:  sdaTarget = 1'b0;
    endcase
  end

  always_comb begin
    phaseNx = phase;
    cntNx   = advance ? cnt + 1'b1 : cnt;
    strb    = '0;
    unique case (phase)
      PH_IDLE: begin
        cntNx = CNT_ZERO;
        if (reqValid)
          phaseNx = (reqOp == OP_START && !sclHeld) ? PH_HIGH : PH_LOWA;
      end
      PH_LOWA: if (atLast) begin
        phaseNx      = PH_LOWB;
        cntNx        = CNT_ZERO;
        strb.sdaLoad = 1'b1;
        strb.sdaVal  = sdaTarget;
      end
      PH_LOWB: if (atLast) begin
        phaseNx      = PH_HIGH;
        cntNx        = CNT_ZERO;
        strb.sclFree = 1'b1;
      end
      PH_HIGH: begin
        if (opR == OP_READ && advance && cnt == (lim >> 1))
          strb.sample = 1'b1;
        if (atLast) begin
          cntNx = CNT_ZERO;
          unique case (opR)
            OP_START: begin
              phaseNx      = PH_HOLD;
              strb.sdaLoad = 1'b1;
              strb.sdaVal  = 1'b1;
            end
            OP_STOP: begin
              phaseNx      = PH_IDLE;
              strb.sdaLoad = 1'b1;
              strb.sdaVal  = 1'b0;
              strb.done    = 1'b1;
            end
            default: begin
              phaseNx      = PH_IDLE;
              strb.sclPull = 1'b1;
              strb.done    = 1'b1;
            end
          endcase
        end
      end
      PH_HOLD: if (atLast) begin
        phaseNx      = PH_IDLE;
        cntNx        = CNT_ZERO;
        strb.sclPull = 1'b1;
        strb.done    = 1'b1;
      end
      default: phaseNx = PH_IDLE;
    endcase
    if (!runEn) begin
      phaseNx = PH_IDLE;
      cntNx   = CNT_ZERO;
      strb    = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= CNT_ZERO;
      opR   <= OP_START;
      bitR  <= 1'b0;
    end else begin
      phase <= phaseNx;
      cnt   <= cntNx;
      if (phase == PH_IDLE && reqValid && runEn) begin
        opR  <= bitOp_e'(reqOp);
        bitR <= reqBit;
      end
    end
  end

  assign reqReady = (phase == PH_IDLE);

  // R8: counter stays at zero while released SCL still reads low
  p_stretch_wait_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH && cnt == CNT_ZERO && !sclIn) |=> (cnt == CNT_ZERO));

  // R5: the datapath has SCL released throughout the high phase
  p_high_released_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH) |-> !sclHeld);

  // R3: SCL still released while a start holds SDA low
  p_hold_scl_free_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HOLD) |-> !sclHeld);

  // R9: withdrawing normal operation parks the generator
  p_disable_idles_r9: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (phase == PH_IDLE) && reqReady);

  // R11: without a request the generator stays idle
  p_idle_stays_r11: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && !reqValid) |=> (phase == PH_IDLE));

endmodule

// File: rtl/i2c_bit_dp.sv
module i2c_bit_dp
  import i2c_bit_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      runEn,
  input  logic      sclRelease,
  input  logic      sdaIn,
  input  lineStrb_t strb,
  output logic      sclPullLow,
  output logic      sdaPullLow,
  output logic      donePulse,
  output logic      rxBit
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPullLow <= 1'b0;
      sdaPullLow <= 1'b0;
      donePulse  <= 1'b0;
      rxBit      <= 1'b0;
    end else if (!runEn) begin
      sclPullLow <= ~sclRelease;
      sdaPullLow <= 1'b0;
      donePulse  <= 1'b0;
    end else begin
      if (strb.sclPull)      sclPullLow <= 1'b1;
      else if (strb.sclFree) sclPullLow <= 1'b0;
      if (strb.sdaLoad)      sdaPullLow <= strb.sdaVal;
      if (strb.sample)       rxBit      <= sdaIn;
      donePulse <= strb.done;
    end
  end

  // R9: forced line state follows the release control one cycle later
  p_forced_lines_r9: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (sclPullLow == !$past(sclRelease)) && !sdaPullLow && !donePulse);

  // R11: completion strobe lasts one cycle
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bit_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             sclRelease,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgDataSetup,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic             reqBit,
  output logic             reqReady,
  output logic             donePulse,
  output logic             rxBit,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclPullLow,
  output logic             sdaPullLow
);

  lineStrb_t strb;

  i2c_bit_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .runEn        (runEn),
    .cfgPeriod    (cfgPeriod),
    .cfgLow       (cfgLow),
    .cfgSetup     (cfgSetup),
    .cfgDataSetup (cfgDataSetup),
    .reqValid     (reqValid),
    .reqOp        (reqOp),
    .reqBit       (reqBit),
    .sclIn        (sclIn),
    .sclHeld      (sclPullLow),
    .reqReady     (reqReady),
    .strb         (strb)
  );

  i2c_bit_dp i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .runEn      (runEn),
    .sclRelease (sclRelease),
    .sdaIn      (sdaIn),
    .strb       (strb),
    .sclPullLow (sclPullLow),
    .sdaPullLow (sdaPullLow),
    .donePulse  (donePulse),
    .rxBit      (rxBit)
  );

endmodule

// File: tb/test_i2c_bit_timer.sv
module test_i2c_bit_timer;

  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b1;
  logic sclRelease = 1'b1;
  logic [CW-1:0] cfgPeriod = 8'd8, cfgLow = 8'd4, cfgSetup = 8'd4, cfgDataSetup = 8'd1;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic reqBit = 1'b0;
  logic reqReady, donePulse, rxBit, sclPullLow, sdaPullLow;
  logic slvScl = 1'b0, slvSda = 1'b0;
  logic sclIn, sdaIn;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // Wired-AND bus with pull-ups
  assign sclIn = ~(sclPullLow | slvScl);
  assign sdaIn = ~(sdaPullLow | slvSda);

  i2c_bit_timer #(.CNT_W(CW)) i_i2c_bit_timer (
    .clk(clk), .rstN(rstN), .runEn(runEn), .sclRelease(sclRelease),
    .cfgPeriod(cfgPeriod), .cfgLow(cfgLow), .cfgSetup(cfgSetup),
    .cfgDataSetup(cfgDataSetup), .reqValid(reqValid), .reqOp(reqOp),
    .reqBit(reqBit), .reqReady(reqReady), .donePulse(donePulse), .rxBit(rxBit),
    .sclIn(sclIn), .sdaIn(sdaIn), .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One operation, measured sample by sample at falling edges
  task automatic doOp(input int op, input bit b, input int st, input bit rdv);
    int P = int'(cfgPeriod), L = int'(cfgLow), D = int'(cfgDataSetup), Su = int'(cfgSetup);
    int H = P - L;
    int lowCnt = 0, tgtLow = 0, rel = 0, relSda = 0, guard = 0;
    int lowExp, tgtExp, relExp, relSdaExp, dScl, dSda;
    bit held, prevSda, seenRel = 0, tgt, readyBad = 0;
    string tag;
    @(negedge clk);
    held = sclPullLow;
    prevSda = sdaPullLow;
    reqValid = 1'b1; reqOp = op[1:0]; reqBit = b;
    slvScl = (st > 0); slvSda = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    case (op)
      1: tgt = ~b;
      3: tgt = 1'b1;
      default: tgt = 1'b0;
    endcase
    while (!donePulse && guard < 2000) begin
      guard++;
      if (reqReady) readyBad = 1;
      if (sclPullLow) begin
        if (!seenRel) begin
          lowCnt++;
          if (sdaPullLow == tgt) tgtLow++;
        end
      end else begin
        seenRel = 1;
        rel++;
        if (sdaPullLow) relSda++;
        if (rel == st + 1) slvScl = 1'b0;
        if (op == 2 && rel >= st + 1)
          slvSda = ((rel - st - 1) == H / 2) ? ~rdv : rdv;
      end
      @(negedge clk);
    end
    slvSda = 1'b0; slvScl = 1'b0;
    case (op)
      0: tag = held ? "R4" : "R3";
      1: tag = "R5";
      2: tag = "R6";
      default: tag = "R7";
    endcase
    lowExp = (op == 0 && !held) ? 0 : L;
    tgtExp = (op == 0 && !held) ? 0 : ((prevSda == tgt) ? L : D);
    case (op)
      0: begin relExp = st + 2 * Su; relSdaExp = Su; dScl = 1; dSda = 1; end
      1: begin relExp = st + H; relSdaExp = b ? 0 : st + H; dScl = 1; dSda = b ? 0 : 1; end
      2: begin relExp = st + H; relSdaExp = 0; dScl = 1; dSda = 0; end
      default: begin relExp = st + Su; relSdaExp = st + Su; dScl = 0; dSda = 0; end
    endcase
    chk("R11", "done seen", int'(donePulse), 1);
    chk(tag, "SCL low cycles", lowCnt, lowExp);
    chk(tag, "SDA target cycles while SCL low", tgtLow, tgtExp);
    chk(st > 0 ? "R8" : tag, "SCL released cycles", rel, relExp);
    chk(tag, "SDA pulled cycles while SCL released", relSda, relSdaExp);
    chk(op == 3 ? "R2" : tag, "SCL enable at done", int'(sclPullLow), dScl);
    chk(op == 3 ? "R2" : tag, "SDA enable at done", int'(sdaPullLow), dSda);
    chk("R11", "ready busy/done", int'(readyBad) * 2 + int'(reqReady), 1);
    if (op == 2) chk(st > 0 ? "R8" : "R6", "rxBit", int'(rxBit), int'(rdv));
    @(negedge clk);
    chk("R11", "done width", int'(donePulse), 0);
    if (op == 3) chk("R2", "bus free after stop", int'(sclPullLow | sdaPullLow), 0);
  endtask

  initial begin
    int seen;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "enables in reset", int'({sclPullLow, sdaPullLow, donePulse}), 0);
    chk("R1", "ready in reset", int'(reqReady), 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "enables after reset", int'({sclPullLow, sdaPullLow, donePulse}), 0);
    chk("R1", "ready after reset", int'(reqReady), 1);

    for (int ci = 0; ci < 4; ci++) begin
      @(negedge clk);
      runEn = 1'b0;
      case (ci)
        0: begin cfgPeriod = 8;  cfgLow = 4; cfgDataSetup = 1; cfgSetup = 4; end
        1: begin cfgPeriod = 12; cfgLow = 5; cfgDataSetup = 2; cfgSetup = 3; end
        2: begin cfgPeriod = 9;  cfgLow = 6; cfgDataSetup = 3; cfgSetup = 2; end
        default: begin cfgPeriod = 10; cfgLow = 3; cfgDataSetup = 1; cfgSetup = 5; end
      endcase
      @(negedge clk);
      runEn = 1'b1;
      doOp(0, 0, 0, 0);
      for (int st = 0; st < 3; st++)
        for (int b = 0; b < 2; b++) begin
          doOp(1, b[0], st, 0);
          doOp(2, 0, st, b[0] ^ st[0]);
        end
      doOp(0, 0, 1, 0);
      doOp(1, 1, 0, 0);
      doOp(3, 0, 2, 0);
      doOp(0, 0, 1, 0);
      doOp(1, 0, 0, 0);
      doOp(3, 0, 0, 0);
    end

    // R9: withdraw normal operation in the middle of a write bit
    doOp(0, 0, 0, 0);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd1; reqBit = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    runEn = 1'b0; sclRelease = 1'b0;
    @(negedge clk);
    chk("R9", "SCL forced low", int'(sclPullLow), 1);
    chk("R9", "SDA released", int'(sdaPullLow), 0);
    chk("R9", "ready when parked", int'(reqReady), 1);
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      reqValid = k[0]; reqOp = 2'd2;
      @(negedge clk);
      if (donePulse || !reqReady || !sclPullLow || sdaPullLow) seen++;
    end
    reqValid = 1'b0;
    chk("R9", "requests ignored while parked", seen, 0);
    sclRelease = 1'b1;
    @(negedge clk);
    chk("R9", "SCL released by control", int'(sclPullLow), 0);
    runEn = 1'b1;
    @(negedge clk);
    chk("R9", "lines after resume", int'({sclPullLow, sdaPullLow}), 0);
    doOp(0, 0, 0, 0);
    doOp(3, 0, 0, 0);

    // R10: request and withdrawal on the same edge
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd0; runEn = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10", "ready after clash", int'(reqReady), 1);
    runEn = 1'b1;
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (donePulse || !reqReady || sclPullLow || sdaPullLow) seen++;
    end
    chk("R10", "discarded request activity", seen, 0);
    doOp(0, 0, 0, 0);
    doOp(3, 0, 1, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog (R1..): run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule